// File: doc/BRIEF.md
# Receive Buffer Descriptor DMA Engine

This block takes incoming frame bytes from a MAC-side byte stream and stores them as 32-bit little-endian words in external memory. Where each frame goes is set by a ring of buffer descriptors in that memory. Each descriptor is two words. Word 0 holds the buffer start address. Word 1 holds ownership in bit 31, status in bits 30:16 and length in bits 15:0. Descriptors are placed every 8 bytes from a base address that software supplies. That base input is never modified; the engine tracks its position with an internal index. A frame that fills one buffer of `BUF_BYTES` continues in the next descriptor. The total length is accumulated and written only into the first and the last descriptor of the frame.

Software loads the base address, the maximum frame length, the ring size and the policy for descriptors the engine does not own, then raises the enable. The engine reports completed frames through a counter that returns to zero whenever the ring wraps, and through a one-cycle interrupt. Memory is reached through a single request/acknowledge port that carries one word per transfer.

The controller is one state machine with these states:
- `S_IDLE`: disabled. It clears the ring position and goes to `S_FETCH_CTL` when enabled.
- `S_FETCH_CTL`: reads descriptor word 1. On acknowledge:
  - back to `S_IDLE` if disabled and no frame is open;
  - to `S_FETCH_BUF` if the descriptor is owned;
  - to `S_ADVANCE` if the descriptor carries the skip bit or the skip policy is set;
  - otherwise to `S_HALT_IRQ`.
- `S_FETCH_BUF`: reads descriptor word 0 and then goes to `S_RECV`.
- `S_RECV`: accepts bytes. It goes to `S_STORE` when a word is complete or the last byte arrives. It goes to `S_IDLE` if disabled before a frame starts.
- `S_STORE`: writes the packed word. Then:
  - to `S_CLOSE_LAST` at end of frame;
  - to `S_ADVANCE` when the buffer is full and the frame is under the maximum;
  - otherwise back to `S_RECV`.
- `S_CLOSE_LAST`: writes back the status word of the current descriptor. It then goes to `S_CLOSE_FIRST` if the frame began in another descriptor, otherwise to `S_DONE`.
- `S_CLOSE_FIRST`: writes the same status word into the first descriptor and goes to `S_DONE`.
- `S_DONE`: raises the interrupt, counts the frame, and goes to `S_ADVANCE`.
- `S_ADVANCE`: steps the ring index, wrapping to 0, and goes to `S_FETCH_CTL`.
- `S_HALT_IRQ`: raises the interrupt and goes to `S_HALT`.
- `S_HALT`: stays idle until the enable drops, then goes to `S_IDLE`.

Top module: `rxbd_dma`

## Requirements
- R1: While reset is held, `mem_req`, `rx_ready` and `irq` are 0 and `frame_cnt` is 0.
- R2: For descriptor i, the engine first reads word 1 at `cfg_base + 8*i + 4`, then word 0 at `cfg_base + 8*i`. Bit 31 of word 1 set to 1 means the engine owns the descriptor.
- R3: Received bytes are packed little-endian, with the first byte in bits 7:0. They are written to consecutive words starting at the descriptor's buffer address. Unused bytes of a partial final word are written as zero.
- R4: At frame end, word 1 is written back as follows, and `irq` pulses for exactly one cycle:
  - bit 31 cleared;
  - bit 16 set when the frame was good;
  - bit 19 set when `rx_err` accompanied the last byte;
  - bits 15:0 hold the length in bytes.
- R5: A frame that fills a buffer of `BUF_BYTES` while under the maximum continues at the next descriptor. The total length and the status are written identically to the first and the last descriptor, and descriptors in between are not written back.
- R6: Once the byte count reaches `cfg_max_len`, the write address stays on that word, and every later word of the frame overwrites it. The status then has bit 20 set and bit 16 clear, and the length field equals `cfg_max_len`.
- R7: The ring holds `cfg_ring_last + 1` descriptors. After the last one the engine returns to descriptor 0. `frame_cnt` increments per completed frame and returns to 0 when the ring wraps.
- R8: Dropping and re-raising `cfg_en` restarts the engine at descriptor 0 with `frame_cnt` at 0.
- R9: An unowned descriptor is passed over with no interrupt when `cfg_skip_unowned` is 1.
- R10: An unowned descriptor whose word 1 has bit 30 (skip) set is passed over with no interrupt, even when `cfg_skip_unowned` is 0.
- R11: An unowned descriptor without the skip bit, with `cfg_skip_unowned` at 0, pulses `irq` and halts. `rx_ready` and `mem_req` then stay low until `cfg_en` drops.
- R12: Once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Receive enable |
| cfg_skip_unowned | input | 1 | 1: pass over unowned descriptors; 0: halt on them |
| cfg_base | input | AW | Address of descriptor 0 |
| cfg_max_len | input | LEN_W | Maximum frame length in bytes |
| cfg_ring_last | input | NBD_W | Index of the last descriptor in the ring |
| rx_valid | input | 1 | Byte present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of the frame |
| rx_err | input | 1 | Frame error flag, taken with the last byte |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer complete |
| frame_cnt | output | CNT_W | Frames completed since the last ring wrap |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check these properties on every cycle:
- the memory handshake holds its request steady;
- write-backs never leave ownership set;
- the interrupt lasts one cycle;
- a halted engine stays silent;
- a frozen write address stays put;
- the ring index stays inside the ring and returns to zero together with the frame count;
- packed words are zero above their filled bytes.

Only the bench's scenarios can show where data and status actually land in memory. That covers:
- a frame split over two descriptors with one shared length;
- the overwritten final word of an oversize frame;
- each of the three outcomes for an unowned descriptor;
- the restart at descriptor 0 after re-enabling.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_CTL,
        S_FETCH_BUF,
        S_RECV,
        S_STORE,
        S_CLOSE_LAST,
        S_CLOSE_FIRST,
        S_DONE,
        S_ADVANCE,
        S_HALT_IRQ,
        S_HALT
    } rxbd_state_e;

    localparam int OWN_BIT  = 31;
    localparam int SKIP_BIT = 30;
    localparam int OVR_BIT  = 20;
    localparam int ERR_BIT  = 19;
    localparam int GOOD_BIT = 16;

endpackage

// File: rtl/rxbd_packer.sv
module rxbd_packer #(
    parameter int BYTES = 4,
    localparam int CW = $clog2(BYTES + 1),
    localparam int IW = $clog2(BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [7:0]           din,
    input  logic                 last_in,
    input  logic                 err_in,
    input  logic                 clr,
    output logic [8*BYTES-1:0]   word,
    output logic                 full,
    output logic                 last,
    output logic                 err
);

    logic [BYTES-1:0][7:0] lanes;
    logic [CW-1:0]         cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lanes <= '0;
            cnt   <= '0;
            last  <= 1'b0;
            err   <= 1'b0;
        end else if (push) begin
            lanes[cnt[IW-1:0]] <= din;
            cnt  <= cnt + 1'b1;
            last <= last_in;
            err  <= err_in & last_in;
        end
    end

    assign word = lanes;
    assign full = (cnt == CW'(BYTES)) || last;

    // R3
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    for (genvar k = 0; k < BYTES; k++) begin : g_pad
        // R3
        pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (full && (int'(cnt) <= k)) |-> (lanes[k] == 8'h00));
    end

endmodule

// File: rtl/rxbd_ring.sv
module rxbd_ring #(
    parameter int NBD_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             bump,
    input  logic [NBD_W-1:0] ring_last,
    output logic [NBD_W-1:0] idx,
    output logic [CNT_W-1:0] cnt
);

    logic wrap;
    assign wrap = step && (idx == ring_last);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
            cnt <= '0;
        end else begin
            if (step)
                idx <= wrap ? '0 : idx + 1'b1;
            if (wrap)
                cnt <= '0;
            else if (bump)
                cnt <= cnt + 1'b1;
        end
    end

    // R7
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        idx <= ring_last);

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (step && idx == ring_last) |=> (idx == '0 && cnt == '0));

endmodule

// File: rtl/rxbd_dma.sv
module rxbd_dma
    import rxbd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NBD_W     = 4,
    parameter int CNT_W     = 5,
    parameter int LEN_W     = 16,
    parameter int BUF_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_skip_unowned,
    input  logic [AW-1:0]    cfg_base,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic [NBD_W-1:0] cfg_ring_last,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             rx_err,
    output logic             rx_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             irq
);

    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int WC_W      = $clog2(BUF_WORDS + 1);

    rxbd_state_e state, state_nx;

    logic [AW-1:0]    wptr;
    logic [WC_W-1:0]  words_in_buf;
    logic [LEN_W:0]   total;
    logic [NBD_W-1:0] first_idx;
    logic             in_frame;
    logic             ferr;

    logic [NBD_W-1:0] idx;
    logic             ring_clr, ring_step, ring_bump;
    logic [31:0]      pk_word;
    logic             pk_full, pk_last, pk_err, pk_clr, push;
    logic             frozen, oversize, buf_end;
    logic [31:0]      wb_word;

    rxbd_ring #(.NBD_W(NBD_W), .CNT_W(CNT_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ring_clr),
        .step      (ring_step),
        .bump      (ring_bump),
        .ring_last (cfg_ring_last),
        .idx       (idx),
        .cnt       (frame_cnt)
    );

    rxbd_packer #(.BYTES(4)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .din     (rx_data),
        .last_in (rx_last),
        .err_in  (rx_err),
        .clr     (pk_clr),
        .word    (pk_word),
        .full    (pk_full),
        .last    (pk_last),
        .err     (pk_err)
    );

    function automatic logic [AW-1:0] desc_addr(input logic [NBD_W-1:0] i);
        return cfg_base + AW'({i, 3'b000});
    endfunction

    assign push     = rx_valid && rx_ready;
    assign frozen   = total >= {1'b0, cfg_max_len};
    assign oversize = total > {1'b0, cfg_max_len};
    assign buf_end  = (words_in_buf + 1'b1) == WC_W'(BUF_WORDS);

    always_comb begin
        wb_word                = '0;
        wb_word[LEN_W-1:0]     = frozen ? cfg_max_len : total[LEN_W-1:0];
        wb_word[OVR_BIT]       = oversize;
        wb_word[ERR_BIT]       = ferr;
        wb_word[GOOD_BIT]      = !oversize && !ferr;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (cfg_en) state_nx = S_FETCH_CTL;
            S_FETCH_CTL: if (mem_ack) begin
                             if (!cfg_en && !in_frame)          state_nx = S_IDLE;
                             else if (mem_rdata[OWN_BIT])       state_nx = S_FETCH_BUF;
                             else if (mem_rdata[SKIP_BIT] || cfg_skip_unowned)
                                                                state_nx = S_ADVANCE;
                             else                               state_nx = S_HALT_IRQ;
                         end
            S_FETCH_BUF: if (mem_ack) state_nx = S_RECV;
            S_RECV:      if (pk_full)                            state_nx = S_STORE;
                         else if (!cfg_en && !in_frame && !push) state_nx = S_IDLE;
            S_STORE:     if (mem_ack) begin
                             if (pk_last)                state_nx = S_CLOSE_LAST;
                             else if (!frozen && buf_end) state_nx = S_ADVANCE;
                             else                        state_nx = S_RECV;
                         end
            S_CLOSE_LAST: if (mem_ack)
                             state_nx = (first_idx != idx) ? S_CLOSE_FIRST : S_DONE;
            S_CLOSE_FIRST: if (mem_ack) state_nx = S_DONE;
            S_DONE:      state_nx = S_ADVANCE;
            S_ADVANCE:   state_nx = S_FETCH_CTL;
            S_HALT_IRQ:  state_nx = S_HALT;
            S_HALT:      if (!cfg_en) state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        irq       = 1'b0;
        ring_clr  = 1'b0;
        ring_step = 1'b0;
        ring_bump = 1'b0;
        pk_clr    = 1'b0;
        unique case (state)
            S_IDLE:        ring_clr = 1'b1;
            S_FETCH_CTL: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr(idx) + AW'(4);
            end
            S_FETCH_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr(idx);
            end
            S_RECV:        rx_ready = !pk_full;
            S_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wptr;
                mem_wdata = pk_word;
                pk_clr    = mem_ack;
            end
            S_CLOSE_LAST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr(idx) + AW'(4);
                mem_wdata = wb_word;
            end
            S_CLOSE_FIRST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr(first_idx) + AW'(4);
                mem_wdata = wb_word;
            end
            S_DONE: begin
                irq       = 1'b1;
                ring_bump = 1'b1;
            end
            S_ADVANCE:     ring_step = 1'b1;
            S_HALT_IRQ:    irq = 1'b1;
            S_HALT:        ;
            default:       ;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n || state == S_IDLE || state == S_DONE) begin
            wptr         <= '0;
            words_in_buf <= '0;
            total        <= '0;
            first_idx    <= '0;
            in_frame     <= 1'b0;
            ferr         <= 1'b0;
        end else begin
            if (state == S_FETCH_BUF && mem_ack) begin
                wptr         <= mem_rdata[AW-1:0];
                words_in_buf <= '0;
            end
            if (push) begin
                in_frame <= 1'b1;
                if (!in_frame) first_idx <= idx;
                if (total != '1) total <= total + 1'b1;
            end
            if (state == S_STORE && mem_ack) begin
                if (pk_err) ferr <= 1'b1;
                if (!frozen) begin
                    wptr         <= wptr + AW'(4);
                    words_in_buf <= words_in_buf + 1'b1;
                end
            end
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R4
    own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (state == S_CLOSE_LAST || state == S_CLOSE_FIRST))
            |-> !mem_wdata[OWN_BIT]);

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT) |-> (!mem_req && !rx_ready));

    // R6
    frozen_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STORE && mem_ack && frozen) |=> (wptr == $past(wptr)));

endmodule

// File: tb/tb_rxbd_dma.sv
`timescale 1ns/1ps
module tb_rxbd_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_skip_unowned = 1'b1;
    logic [31:0] cfg_base = 32'h0;
    logic [15:0] cfg_max_len = 16'd64;
    logic [3:0]  cfg_ring_last = 4'd3;
    logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_ready, mem_req, mem_we, mem_ack, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [4:0]  frame_cnt;

    logic [31:0] mem [0:255];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_idx = 8'h0;
    logic [31:0] poke_val = 32'h0;

    int n_chk = 0, n_bad = 0, irq_cnt = 0, req_cyc = 0, hold_viol = 0, cyc = 0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = 32'h0;

    always #2.5 clk = ~clk;

    rxbd_dma dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_skip_unowned(cfg_skip_unowned),
        .cfg_base(cfg_base), .cfg_max_len(cfg_max_len), .cfg_ring_last(cfg_ring_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .frame_cnt(frame_cnt), .irq(irq)
    );

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= 32'h0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end else begin
            mem_ack <= 1'b0;
            if (poke_en) mem[poke_idx] <= poke_val;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_cnt++;
            if (mem_req) req_cyc++;
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_viol++;
            prev_pend = mem_req && !mem_ack;
            prev_addr = mem_addr;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            finish_run();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(int i, logic [31:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = 8'(i); poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // disable, refill descriptors and buffers, apply config (engine left disabled)
    task automatic configure(logic [15:0] maxl, logic skipp);
        @(negedge clk); cfg_en = 1'b0;
        repeat (8) @(negedge clk);
        cfg_max_len = maxl; cfg_skip_unowned = skipp; cfg_ring_last = 4'd3;
        for (int i = 0; i < 16; i++) begin
            poke(2*i, 32'h100 + 32'(i) * 32'h20);
            poke(2*i + 1, 32'h8000_0000);
        end
        for (int w = 64; w < 192; w++) poke(w, 32'hDEAD_BEEF);
    endtask

    task automatic send(int n, logic [7:0] first, logic err);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_data = first + 8'(i);
            rx_last = (i == n - 1); rx_err = err && (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic wait_irq(int target);
        while (irq_cnt < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_basic();
        int b;
        configure(16'd64, 1'b1);
        cfg_en = 1'b1;
        b = irq_cnt;
        send(6, 8'h10, 1'b0);
        wait_irq(b + 1);
        check("R3 word0", mem[64], 32'h1312_1110);
        check("R3 padded word1", mem[65], 32'h0000_1514);
        check("R3 past end untouched", mem[66], 32'hDEAD_BEEF);
        check("R2 R4 status desc0", mem[1], 32'h0001_0006);
        check("R7 frame_cnt", 32'(frame_cnt), 32'd1);
        // R4 error frame into desc1
        b = irq_cnt;
        send(4, 8'h20, 1'b1);
        wait_irq(b + 1);
        check("R4 err data", mem[72], 32'h2322_2120);
        check("R4 err status", mem[3], 32'h0008_0004);
        check("R7 frame_cnt 2", 32'(frame_cnt), 32'd2);
    endtask

    task automatic t_multi();
        int b;
        b = irq_cnt;
        send(20, 8'h40, 1'b0);
        wait_irq(b + 1);
        check("R5 buf2 w0", mem[80], 32'h4342_4140);
        check("R5 buf2 w3", mem[83], 32'h4F4E_4D4C);
        check("R5 buf3 w0", mem[88], 32'h5352_5150);
        check("R5 first desc status", mem[5], 32'h0001_0014);
        check("R5 last desc status", mem[7], 32'h0001_0014);
        check("R7 wrap clears frame_cnt", 32'(frame_cnt), 32'd0);
        check("R4 one irq per frame", 32'(irq_cnt - b), 32'd1);
    endtask

    task automatic t_oversize();
        int b;
        configure(16'd8, 1'b1);
        cfg_en = 1'b1;
        b = irq_cnt;
        send(14, 8'h60, 1'b0);
        wait_irq(b + 1);
        check("R6 word0", mem[64], 32'h6362_6160);
        check("R6 overwritten last word", mem[65], 32'h0000_6D6C);
        check("R6 no write past max", mem[66], 32'hDEAD_BEEF);
        check("R6 status", mem[1], 32'h0010_0008);
    endtask

    task automatic t_skip_policy();
        int b;
        configure(16'd64, 1'b1);
        poke(1, 32'h0);
        cfg_en = 1'b1;
        b = irq_cnt;
        send(4, 8'h70, 1'b0);
        wait_irq(b + 1);
        check("R9 lands in desc1", mem[72], 32'h7372_7170);
        check("R9 desc1 status", mem[3], 32'h0001_0004);
        check("R9 desc0 untouched", mem[1], 32'h0);
        check("R9 no extra irq", 32'(irq_cnt - b), 32'd1);
    endtask

    task automatic t_skip_bit();
        int b;
        configure(16'd64, 1'b0);
        poke(1, 32'h4000_0000);
        cfg_en = 1'b1;
        b = irq_cnt;
        send(4, 8'h80, 1'b0);
        wait_irq(b + 1);
        check("R10 lands in desc1", mem[72], 32'h8382_8180);
        check("R10 desc0 untouched", mem[1], 32'h4000_0000);
        check("R10 no halt irq", 32'(irq_cnt - b), 32'd1);
    endtask

    task automatic t_halt();
        int b, r0;
        logic saw_ready;
        configure(16'd64, 1'b0);
        poke(3, 32'h0);
        cfg_en = 1'b1;
        b = irq_cnt;
        send(4, 8'h90, 1'b0);
        wait_irq(b + 2);
        check("R11 frame irq plus halt irq", 32'(irq_cnt - b), 32'd2);
        check("R11 frame stored", mem[64], 32'h9392_9190);
        r0 = req_cyc;
        saw_ready = 1'b0;
        rx_valid = 1'b1; rx_data = 8'hEE;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rx_ready) saw_ready = 1'b1;
        end
        rx_valid = 1'b0;
        check("R11 no ready while halted", 32'(saw_ready), 32'd0);
        check("R11 no memory traffic while halted", 32'(req_cyc - r0), 32'd0);
        // R8 restart at descriptor 0
        cfg_en = 1'b0;
        repeat (4) @(negedge clk);
        poke(1, 32'h8000_0000);
        cfg_skip_unowned = 1'b1;
        @(negedge clk); cfg_en = 1'b1;
        b = irq_cnt;
        send(4, 8'hA0, 1'b0);
        wait_irq(b + 1);
        check("R8 restart uses desc0", mem[64], 32'hA3A2_A1A0);
        check("R8 frame_cnt restarted", 32'(frame_cnt), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 rx_ready", 32'(rx_ready), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 frame_cnt", 32'(frame_cnt), 32'd0);
        rst_n = 1'b1;
        t_basic();
        t_multi();
        t_oversize();
        t_skip_policy();
        t_skip_bit();
        t_halt();
        check("R12 request held until ack", 32'(hold_viol), 32'd0);
        finish_run();
    end

endmodule